// File: doc/BRIEF.md
# Incoming Packet Acceptance Filter

This block sits behind the receive side of a serial-bus link layer. For every received packet header it makes one decision: keep the packet or drop it. It passes that decision on as a single-cycle accept or reject pulse. The payload and its CRC are handled elsewhere. The filter sees only a header-valid strobe, the destination bus and node numbers, a two-bit packet class and a few control bits.

Asynchronous packets must carry the local 10-bit bus number and either the local 6-bit node number or the all-ones broadcast node number. They are also accepted only while the local identity is marked valid. Isochronous packets pass by default. When strict timing is switched on, an isochronous packet is kept only if it arrives inside the isochronous window. That window opens on a received cycle-start packet and closes at the subaction gap or at bus reset. The receiver enable bit gates every decision.

Top module: `rx_accept_filter`

## Requirements
- R1: Each cycle with `hdr_valid`=1 yields, exactly one clock later, a one-cycle pulse on exactly one of `accept` or `reject`. Neither output is ever high in any other cycle, and the two are never high together.
- R2: While `rx_en`=0 in the header cycle, every header is rejected, whatever its class.
- R3: An asynchronous header (`hdr_class`=2'b00) is rejected while `id_valid`=0, even when its destination matches.
- R4: With `id_valid`=1, an asynchronous header is accepted only when `dst_bus` equals `local_bus` and `dst_node` equals `local_node`. A mismatch in either field rejects it.
- R5: An asynchronous header whose `dst_node` is all ones (63) is accepted for any `local_node`, provided `dst_bus` equals `local_bus` and `id_valid`=1. With a bus mismatch it is rejected.
- R6: With `strict_iso`=0, an isochronous header (`hdr_class`=2'b01) is accepted whether the window is open or closed. Its destination fields are not compared.
- R7: With `strict_iso`=1, an isochronous header is accepted only while the isochronous window is open, and is rejected otherwise.
- R8: A `cyc_start` pulse opens the window from the next cycle. A `sub_gap` or `bus_reset` pulse closes it from the next cycle, and closing wins when it coincides with `cyc_start`. A header is judged on the window state held at the start of its own cycle, so events in that same cycle do not affect it.
- R9: Headers with a reserved class (`hdr_class`=2'b10 or 2'b11) are always rejected.
- R10: After `rst_n` is asserted low, `accept` and `reject` are 0 and the window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable; 0 rejects every header |
| id_valid | input | 1 | Local bus/node identity is valid |
| strict_iso | input | 1 | 1 = isochronous packets only inside the window |
| local_bus | input | 10 | Local bus number |
| local_node | input | 6 | Local node number |
| bus_reset | input | 1 | Bus-reset strobe; closes the window |
| cyc_start | input | 1 | Cycle-start-received strobe; opens the window |
| sub_gap | input | 1 | Subaction-gap strobe; closes the window |
| hdr_valid | input | 1 | Header fields below are valid this cycle |
| hdr_class | input | 2 | 00 asynchronous, 01 isochronous, 1x reserved |
| dst_bus | input | 10 | Destination bus number of the header |
| dst_node | input | 6 | Destination node number of the header |
| accept | output | 1 | One-cycle pulse: previous header accepted |
| reject | output | 1 | One-cycle pulse: previous header rejected |

## Verification
The hardest case to reach from the ports is a header that arrives in the same cycle as a window event. Two sub-cases matter: a cycle-start together with a strict isochronous header, and a cycle-start that coincides with a subaction gap. Here the decision depends on window state that cannot be seen at the ports. Directed tasks place the header strobe and the event strobes in the same cycle on purpose, and also on either side of it. After that, a long random phase raises the event strobes often enough that such collisions occur many times. A behavioural reference model tracks the window and predicts each pulse on every clock.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        PKT_ASYNC = 2'b00,
        PKT_ISO   = 2'b01,
        PKT_RSV2  = 2'b10,
        PKT_RSV3  = 2'b11
    } pkt_class_e;

    typedef struct packed {
        logic accept;
        logic reject;
    } verdict_t;

    typedef struct packed {
        logic open;
    } win_state_t;

endpackage

// File: rtl/rxf_window.sv
module rxf_window (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic cyc_start,
    input  logic sub_gap,
    output logic win_open
);
    import rxf_pkg::*;

    win_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (bus_reset || sub_gap) begin
            st_d.open = 1'b0;
        end else if (cyc_start) begin
            st_d.open = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign win_open = st_q.open;

endmodule

// File: rtl/rxf_dest_match.sv
module rxf_dest_match #(
    parameter int BUS_W  = 10,
    parameter int NODE_W = 6
) (
    input  logic [BUS_W-1:0]  local_bus,
    input  logic [NODE_W-1:0] local_node,
    input  logic [BUS_W-1:0]  dst_bus,
    input  logic [NODE_W-1:0] dst_node,
    output logic              addr_hit
);
    localparam logic [NODE_W-1:0] BCAST_NODE = {NODE_W{1'b1}};

    logic bus_eq;
    logic node_eq;
    logic node_bcast;

    always_comb begin
        bus_eq     = (dst_bus == local_bus);
        node_eq    = (dst_node == local_node);
        node_bcast = (dst_node == BCAST_NODE);
        addr_hit   = bus_eq && (node_eq || node_bcast);
    end

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hdr_valid,
    input  logic [1:0] hdr_class,
    input  logic       rx_en,
    input  logic       id_valid,
    input  logic       strict_iso,
    input  logic       win_open,
    input  logic       addr_hit,
    output logic       accept,
    output logic       reject
);
    import rxf_pkg::*;

    verdict_t   vd_d, vd_q;
    pkt_class_e cls;
    logic       keep;

    always_comb begin
        cls  = pkt_class_e'(hdr_class);
        keep = 1'b0;
        unique case (cls)
            PKT_ASYNC: keep = id_valid && addr_hit;
            PKT_ISO:   keep = !strict_iso || win_open;
            default:   keep = 1'b0;
        endcase
        keep = keep && rx_en;

        vd_d.accept = hdr_valid && keep;
        vd_d.reject = hdr_valid && !keep;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vd_q <= '0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign accept = vd_q.accept;
    assign reject = vd_q.reject;

endmodule

// File: rtl/rx_accept_filter.sv
module rx_accept_filter #(
    parameter int BUS_W  = 10,
    parameter int NODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_en,
    input  logic              id_valid,
    input  logic              strict_iso,
    input  logic [BUS_W-1:0]  local_bus,
    input  logic [NODE_W-1:0] local_node,
    input  logic              bus_reset,
    input  logic              cyc_start,
    input  logic              sub_gap,
    input  logic              hdr_valid,
    input  logic [1:0]        hdr_class,
    input  logic [BUS_W-1:0]  dst_bus,
    input  logic [NODE_W-1:0] dst_node,
    output logic              accept,
    output logic              reject
);
    logic win_open;
    logic addr_hit;

    rxf_window u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .cyc_start (cyc_start),
        .sub_gap   (sub_gap),
        .win_open  (win_open)
    );

    rxf_dest_match #(
        .BUS_W  (BUS_W),
        .NODE_W (NODE_W)
    ) u_match (
        .local_bus  (local_bus),
        .local_node (local_node),
        .dst_bus    (dst_bus),
        .dst_node   (dst_node),
        .addr_hit   (addr_hit)
    );

    rxf_decide u_decide (
        .clk        (clk),
        .rst_n      (rst_n),
        .hdr_valid  (hdr_valid),
        .hdr_class  (hdr_class),
        .rx_en      (rx_en),
        .id_valid   (id_valid),
        .strict_iso (strict_iso),
        .win_open   (win_open),
        .addr_hit   (addr_hit),
        .accept     (accept),
        .reject     (reject)
    );

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en,
    input logic       id_valid,
    input logic       strict_iso,
    input logic       bus_reset,
    input logic       cyc_start,
    input logic       sub_gap,
    input logic       hdr_valid,
    input logic [1:0] hdr_class,
    input logic       win_open,
    input logic       accept,
    input logic       reject
);

    a_r1_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(accept && reject));

    a_r1_only_after_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        (accept || reject) |-> $past(hdr_valid));

    a_r1_every_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> (accept || reject));

    a_r2_rx_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && !rx_en) |=> reject);

    a_r3_id_needed: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_class == 2'b00 && !id_valid) |=> reject);

    a_r7_strict_window: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_class == 2'b01 && strict_iso && !win_open) |=> reject);

    a_r8_close: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_gap || bus_reset) |=> !win_open);

    a_r8_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && !sub_gap && !bus_reset) |=> win_open);

    a_r9_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_valid && hdr_class[1]) |=> reject);

endmodule

bind rx_accept_filter rxf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_en      (rx_en),
    .id_valid   (id_valid),
    .strict_iso (strict_iso),
    .bus_reset  (bus_reset),
    .cyc_start  (cyc_start),
    .sub_gap    (sub_gap),
    .hdr_valid  (hdr_valid),
    .hdr_class  (hdr_class),
    .win_open   (win_open),
    .accept     (accept),
    .reject     (reject)
);

// File: tb/rx_accept_filter_bench.sv
`timescale 1ns/1ps
module rx_accept_filter_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_en = 1'b0;
    logic       id_valid = 1'b0;
    logic       strict_iso = 1'b0;
    logic [9:0] local_bus = 10'h155;
    logic [5:0] local_node = 6'h0A;
    logic       bus_reset = 1'b0;
    logic       cyc_start = 1'b0;
    logic       sub_gap = 1'b0;
    logic       hdr_valid = 1'b0;
    logic [1:0] hdr_class = 2'b00;
    logic [9:0] dst_bus = '0;
    logic [5:0] dst_node = '0;
    logic       accept;
    logic       reject;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R10";
    bit    done = 1'b0;

    // behavioural reference model
    bit m_win = 1'b0;
    bit exp_a = 1'b0;
    bit exp_r = 1'b0;

    always #2 clk = ~clk;

    rx_accept_filter u_rx_accept_filter (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .id_valid(id_valid),
        .strict_iso(strict_iso), .local_bus(local_bus), .local_node(local_node),
        .bus_reset(bus_reset), .cyc_start(cyc_start), .sub_gap(sub_gap),
        .hdr_valid(hdr_valid), .hdr_class(hdr_class), .dst_bus(dst_bus),
        .dst_node(dst_node), .accept(accept), .reject(reject)
    );

    function automatic bit model_keep();
        bit k;
        k = 1'b0;
        if (hdr_class == 2'b00)
            k = id_valid && (dst_bus == local_bus) &&
                ((dst_node == local_node) || (dst_node == 6'd63));
        else if (hdr_class == 2'b01)
            k = !strict_iso || m_win;
        return k && rx_en;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_win <= 1'b0;
            exp_a <= 1'b0;
            exp_r <= 1'b0;
        end else begin
            exp_a <= hdr_valid && model_keep();
            exp_r <= hdr_valid && !model_keep();
            if (bus_reset || sub_gap) m_win <= 1'b0;
            else if (cyc_start)       m_win <= 1'b1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (accept !== exp_a || reject !== exp_r) begin
                errors++;
                $display("FAIL %s per-cycle: accept/reject=%b%b expected %b%b",
                         cur_req, accept, reject, exp_a, exp_r);
            end
        end
    end

    task automatic expect_out(input bit ea, input string req);
        checks++;
        if (accept !== ea || reject !== !ea) begin
            errors++;
            $display("FAIL %s directed: accept/reject=%b%b expected %b%b",
                     req, accept, reject, ea, !ea);
        end
    endtask

    // one header, optionally with window events in the same cycle
    task automatic hdr_ev(input logic [1:0] cls, input logic [9:0] b, input logic [5:0] n,
                          input bit cs, input bit sg, input bit ea, input string req);
        cur_req = req;
        @(negedge clk);
        hdr_valid = 1'b1; hdr_class = cls; dst_bus = b; dst_node = n;
        cyc_start = cs; sub_gap = sg;
        @(negedge clk);
        hdr_valid = 1'b0; cyc_start = 1'b0; sub_gap = 1'b0;
        expect_out(ea, req);
    endtask

    task automatic hdr(input logic [1:0] cls, input logic [9:0] b, input logic [5:0] n,
                       input bit ea, input string req);
        hdr_ev(cls, b, n, 1'b0, 1'b0, ea, req);
    endtask

    task automatic events(input bit cs, input bit sg, input bit br);
        @(negedge clk);
        cyc_start = cs; sub_gap = sg; bus_reset = br;
        @(negedge clk);
        cyc_start = 1'b0; sub_gap = 1'b0; bus_reset = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        cur_req = "R10";
        checks++;
        if (accept !== 1'b0 || reject !== 1'b0) begin
            errors++;
            $display("FAIL R10 reset: accept/reject=%b%b expected 00", accept, reject);
        end
        rst_n = 1'b1; rx_en = 1'b1; id_valid = 1'b1;
        // R10: window closed after reset -> strict iso rejected
        strict_iso = 1'b1;
        hdr(2'b01, 10'h000, 6'h00, 1'b0, "R10");
        strict_iso = 1'b0;

        hdr(2'b00, 10'h155, 6'h0A, 1'b1, "R4");
        hdr(2'b00, 10'h155, 6'h0B, 1'b0, "R4");
        hdr(2'b00, 10'h154, 6'h0A, 1'b0, "R4");
        hdr(2'b00, 10'h155, 6'h3F, 1'b1, "R5");
        hdr(2'b00, 10'h3FF, 6'h3F, 1'b0, "R5");
        id_valid = 1'b0;
        hdr(2'b00, 10'h155, 6'h0A, 1'b0, "R3");
        hdr(2'b00, 10'h155, 6'h3F, 1'b0, "R3");
        id_valid = 1'b1;

        hdr(2'b01, 10'h2AA, 6'h11, 1'b1, "R6");
        events(1'b1, 1'b0, 1'b0);
        hdr(2'b01, 10'h2AA, 6'h11, 1'b1, "R6");
        events(1'b0, 1'b1, 1'b0);

        strict_iso = 1'b1;
        hdr(2'b01, 10'h000, 6'h00, 1'b0, "R7");
        events(1'b1, 1'b0, 1'b0);
        hdr(2'b01, 10'h000, 6'h00, 1'b1, "R7");
        hdr(2'b01, 10'h000, 6'h00, 1'b1, "R8");
        events(1'b0, 1'b1, 1'b0);
        hdr(2'b01, 10'h000, 6'h00, 1'b0, "R8");
        events(1'b1, 1'b0, 1'b0);
        events(1'b0, 1'b0, 1'b1);
        hdr(2'b01, 10'h000, 6'h00, 1'b0, "R8");
        events(1'b1, 1'b1, 1'b0);
        hdr(2'b01, 10'h000, 6'h00, 1'b0, "R8");
        // same-cycle events: header sees the state at start of its cycle
        hdr_ev(2'b01, 10'h000, 6'h00, 1'b1, 1'b0, 1'b0, "R8");
        hdr(2'b01, 10'h000, 6'h00, 1'b1, "R8");
        hdr_ev(2'b01, 10'h000, 6'h00, 1'b0, 1'b1, 1'b1, "R8");
        hdr(2'b01, 10'h000, 6'h00, 1'b0, "R8");
        strict_iso = 1'b0;

        hdr(2'b10, 10'h155, 6'h0A, 1'b0, "R9");
        hdr(2'b11, 10'h155, 6'h0A, 1'b0, "R9");

        rx_en = 1'b0;
        hdr(2'b00, 10'h155, 6'h0A, 1'b0, "R2");
        hdr(2'b01, 10'h155, 6'h0A, 1'b0, "R2");
        rx_en = 1'b1;

        // R1: back-to-back headers, one pulse per header
        cur_req = "R1";
        @(negedge clk);
        hdr_valid = 1'b1; hdr_class = 2'b00; dst_bus = 10'h155; dst_node = 6'h0A;
        @(negedge clk);
        hdr_class = 2'b10;
        expect_out(1'b1, "R1");
        @(negedge clk);
        hdr_valid = 1'b0;
        expect_out(1'b0, "R1");
        @(negedge clk);
        checks++;
        if (accept !== 1'b0 || reject !== 1'b0) begin
            errors++;
            $display("FAIL R1 idle: accept/reject=%b%b expected 00", accept, reject);
        end

        // random phase, checked against the model every clock
        cur_req = "R1";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            hdr_valid  = ($urandom_range(0, 2) != 0);
            hdr_class  = 2'($urandom_range(0, 3));
            dst_bus    = ($urandom_range(0, 3) != 0) ? local_bus : 10'($urandom);
            dst_node   = ($urandom_range(0, 2) == 0) ? local_node :
                         (($urandom_range(0, 2) == 0) ? 6'h3F : 6'($urandom));
            cyc_start  = ($urandom_range(0, 5) == 0);
            sub_gap    = ($urandom_range(0, 6) == 0);
            bus_reset  = ($urandom_range(0, 40) == 0);
            rx_en      = ($urandom_range(0, 9) != 0);
            id_valid   = ($urandom_range(0, 7) != 0);
            strict_iso = ($urandom_range(0, 1) != 0);
            if (i % 500 == 250) local_node = 6'($urandom);
        end
        @(negedge clk);
        hdr_valid = 1'b0; cyc_start = 1'b0; sub_gap = 1'b0; bus_reset = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule